// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs a single data port with a strobe/acknowledge handshake toward a peripheral. It also raises an interrupt request toward the CPU. One input picks the direction. In the input direction, the peripheral pulls its strobe low and the block captures the pin data and raises an input-full flag. The flag stays up until the CPU has finished reading the captured byte. In the output direction, a CPU write loads the output latch and drives an active-low output-full line. The peripheral's acknowledge pulse releases that line.

Interrupt requests are gated by an internal enable bit. The CPU sets or clears that bit with a single-bit set/reset command. The command addresses the same bit number that the strobe or acknowledge pin occupies on the status byte. A status byte shows the interrupt request, the enable and the buffer flag at fixed bit positions, and a neighbouring port-status mux merges it. The parameter `PORT_B` selects which of two position layouts is used. The strobe/acknowledge line is asynchronous and is resynchronised inside the block. The CPU read and write strobes are synchronous to the block clock.

Top module: `hs_port_ctrl`

## Requirements
- R1: After reset the input-full flag is 0, the output-full line is 1 (idle), the enable and interrupt request are 0, and both data latches are 0.
- R2: In the input direction, a low pulse on `stb_ack_ni` (held at least 4 clock cycles) captures `pin_data_i` into `rd_data_o` and sets `buf_flag_o` to 1. In the output direction, a strobe does not change `rd_data_o`.
- R3: In the input direction, the input-full flag stays set while `rd_ni` is low and clears once `rd_ni` returns high. The interrupt request clears in the cycle after `rd_ni` falls.
- R4: In the input direction, the interrupt request rises only when the synchronised strobe is high, the input-full flag is 1, the enable is 1 and no read is in progress.
- R5: In the output direction, the rising edge of `wr_ni` loads `cpu_wdata_i` into `port_data_o` and drives `buf_flag_o` low. A low pulse on `stb_ack_ni` then returns it high. In the input direction, writes leave `port_data_o` unchanged.
- R6: In the output direction, the interrupt request rises only when `buf_flag_o` is high, the acknowledge is high, the enable is 1 and no write is in progress. It clears in the cycle after `wr_ni` falls.
- R7: A set/reset command (`bsr_we_i`, `bsr_bit_i`, `bsr_val_i`) changes the enable only when `bsr_bit_i` equals the enable position: 4 (input) or 6 (output) for port A, and 2 for port B. Commands to any other bit leave the enable, the interrupt and the flags unchanged. Clearing the enable drops the interrupt request in the same cycle.
- R8: Status byte layout for port A is interrupt request at bit 3, enable at bit 4 (input) or bit 6 (output), and input-full at bit 5 or output-full at bit 7. For port B it is interrupt request at bit 0, buffer flag at bit 1 and enable at bit 2. All other bits read 0.
- R9: A change of `dir_in_i` clears the input-full flag, releases the output-full line, and clears the enable and the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_in_i | input | 1 | 1 = input direction, 0 = output direction |
| pin_data_i | input | DATA_W | Peripheral data pins (input direction) |
| stb_ack_ni | input | 1 | Peripheral strobe (input) or acknowledge (output), active low, asynchronous |
| rd_ni | input | 1 | CPU read strobe of the port data, active low |
| wr_ni | input | 1 | CPU write strobe of the port data, active low |
| cpu_wdata_i | input | DATA_W | CPU write data |
| bsr_we_i | input | 1 | One-cycle single-bit set/reset command |
| bsr_bit_i | input | 3 | Bit number addressed by the command |
| bsr_val_i | input | 1 | Value written by the command |
| rd_data_o | output | DATA_W | Captured input byte |
| port_data_o | output | DATA_W | Output latch toward the peripheral |
| buf_flag_o | output | 1 | Input-full (active high) or output-full (active low) |
| intr_o | output | 1 | Interrupt request |
| status_o | output | 8 | Handshake status byte at fixed positions |

## Verification
The assertions assume that the CPU read and write strobes never fall or rise in the same cycle as a synchronised strobe/acknowledge edge. They also assume that pin data holds still while the strobe is low and that a direction change is not combined with a handshake event. The stimulus keeps to these rules in two ways. It runs each handshake, read, write, set/reset command and direction change as a separate operation with idle cycles between them. It also holds data and strobe pulses for several cycles so that they pass the two-stage synchroniser.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;
  localparam int unsigned STAT_W = 8;

  typedef struct packed {
    logic [2:0] intr;
    logic [2:0] inte;
    logic [2:0] bf;
  } pc_pos_t;

  // fixed handshake bit positions; inte position doubles as set/reset target
  function automatic pc_pos_t pc_pos(input logic port_b, input logic dir_in);
    pc_pos_t p;
    if (port_b) begin
      p.intr = 3'd0; p.bf = 3'd1; p.inte = 3'd2;
    end else if (dir_in) begin
      p.intr = 3'd3; p.inte = 3'd4; p.bf = 3'd5;
    end else begin
      p.intr = 3'd3; p.inte = 3'd6; p.bf = 3'd7;
    end
    return p;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b1;
        else if (i == 0) chain_q[i] <= async_i;
        else chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];
  assign rise_o  = ~chain_q[STAGES] & chain_q[STAGES-1];
endmodule

// File: rtl/hs_flags.sv
module hs_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_in_i,
  input  logic [2:0]        inte_pos_i,
  input  logic              hs_level_i,
  input  logic              hs_fall_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] pin_data_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              bsr_we_i,
  input  logic [2:0]        bsr_bit_i,
  input  logic              bsr_val_i,
  output logic              ibf_o,
  output logic              obf_n_o,
  output logic              inte_o,
  output logic              intr_o,
  output logic [DATA_W-1:0] in_latch_o,
  output logic [DATA_W-1:0] out_latch_o
);
  logic rd_q, wr_q, dir_q;
  logic ibf_q, obf_n_q, inte_q, intr_q;
  logic inte_d;
  logic [DATA_W-1:0] in_q, out_q;

  wire dir_chg = dir_q != dir_in_i;
  wire rd_fall = rd_q & ~rd_ni;
  wire rd_rise = ~rd_q & rd_ni;
  wire wr_fall = wr_q & ~wr_ni;
  wire wr_rise = ~wr_q & wr_ni;
  wire bsr_hit = bsr_we_i && (bsr_bit_i == inte_pos_i);

  always_comb begin
    if (dir_chg)      inte_d = 1'b0;
    else if (bsr_hit) inte_d = bsr_val_i;
    else              inte_d = inte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b1; wr_q <= 1'b1; dir_q <= 1'b1;
    end else begin
      rd_q <= rd_ni; wr_q <= wr_ni; dir_q <= dir_in_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q <= 1'b0; obf_n_q <= 1'b1; inte_q <= 1'b0; intr_q <= 1'b0;
      in_q <= '0; out_q <= '0;
    end else if (dir_chg) begin
      ibf_q <= 1'b0; obf_n_q <= 1'b1; inte_q <= 1'b0; intr_q <= 1'b0;
    end else begin
      inte_q <= inte_d;
      if (dir_in_i) begin
        if (hs_fall_i) begin
          ibf_q <= 1'b1;
          in_q  <= pin_data_i;
        end else if (rd_rise) begin
          ibf_q <= 1'b0;
        end
        if (!inte_d || rd_fall) intr_q <= 1'b0;
        else if (hs_level_i && ibf_q && rd_q) intr_q <= 1'b1;
      end else begin
        if (wr_rise) begin
          obf_n_q <= 1'b0;
          out_q   <= cpu_wdata_i;
        end else if (hs_fall_i) begin
          obf_n_q <= 1'b1;
        end
        if (!inte_d || wr_fall) intr_q <= 1'b0;
        else if (hs_level_i && obf_n_q && wr_q) intr_q <= 1'b1;
      end
    end
  end

  assign ibf_o = ibf_q;
  assign obf_n_o = obf_n_q;
  assign inte_o = inte_q;
  assign intr_o = intr_q;
  assign in_latch_o = in_q;
  assign out_latch_o = out_q;

  p_ibf_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_in_i && !dir_chg && hs_fall_i) |=> ibf_q);
  p_ibf_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_in_i && rd_rise && !hs_fall_i) |=> !ibf_q);
  p_intr_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_in_i && rd_fall) |=> !intr_q);
  p_intr_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_q |-> inte_q);
  p_obf_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_in_i && !dir_chg && wr_rise) |=> !obf_n_q);
  p_intr_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_in_i && wr_fall) |=> !intr_q);
  p_inte_other_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bsr_we_i && bsr_bit_i != inte_pos_i && !dir_chg) |=> $stable(inte_q));
  p_dir_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_chg |=> (!intr_q && !inte_q && !ibf_q && obf_n_q));
endmodule

// File: rtl/hs_status.sv
module hs_status
  import hs_port_pkg::*;
(
  input  logic              dir_in_i,
  input  pc_pos_t           pos_i,
  input  logic              ibf_i,
  input  logic              obf_n_i,
  input  logic              inte_i,
  input  logic              intr_i,
  output logic [STAT_W-1:0] status_o
);
  always_comb begin
    status_o = '0;
    status_o[pos_i.intr] = intr_i;
    status_o[pos_i.inte] = inte_i;
    status_o[pos_i.bf]   = dir_in_i ? ibf_i : obf_n_i;
  end

  always_comb begin
    p_status_mask_r8: assert ($countones(status_o) <= 3);
  end
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl
  import hs_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          PORT_B      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_in_i,
  input  logic [DATA_W-1:0] pin_data_i,
  input  logic              stb_ack_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              bsr_we_i,
  input  logic [2:0]        bsr_bit_i,
  input  logic              bsr_val_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] port_data_o,
  output logic              buf_flag_o,
  output logic              intr_o,
  output logic [STAT_W-1:0] status_o
);
  pc_pos_t pos;
  logic hs_level, hs_fall, hs_rise;
  logic ibf, obf_n, inte, intr;

  always_comb pos = pc_pos(PORT_B, dir_in_i);

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(stb_ack_ni),
    .level_o(hs_level), .fall_o(hs_fall), .rise_o(hs_rise)
  );

  hs_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_in_i(dir_in_i),
    .inte_pos_i(pos.inte), .hs_level_i(hs_level), .hs_fall_i(hs_fall),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .pin_data_i(pin_data_i),
    .cpu_wdata_i(cpu_wdata_i), .bsr_we_i(bsr_we_i), .bsr_bit_i(bsr_bit_i),
    .bsr_val_i(bsr_val_i), .ibf_o(ibf), .obf_n_o(obf_n), .inte_o(inte),
    .intr_o(intr), .in_latch_o(rd_data_o), .out_latch_o(port_data_o)
  );

  hs_status u_status (
    .dir_in_i(dir_in_i), .pos_i(pos), .ibf_i(ibf), .obf_n_i(obf_n),
    .inte_i(inte), .intr_i(intr), .status_o(status_o)
  );

  assign buf_flag_o = dir_in_i ? ibf : obf_n;
  assign intr_o = intr;

  // acknowledge rising edge alone never changes the output-full line
  p_ack_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_in_i && $stable(dir_in_i) && hs_rise && rd_ni && wr_ni) |=> $stable(obf_n));
endmodule

// File: tb/hs_port_ctrl_tb.sv
module hs_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_in = 1'b1;
  logic [W-1:0] pin_data = '0;
  logic stb_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [W-1:0] wdata = '0;
  logic bsr_we = 1'b0, bsr_val = 1'b0;
  logic [2:0] bsr_bit = '0;

  logic [W-1:0] rdat [2];
  logic [W-1:0] pdat [2];
  logic bflag [2];
  logic intr [2];
  logic [7:0] stat [2];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic m_ibf [2];
  logic m_obfn [2];
  logic m_inte [2];
  logic [W-1:0] m_in, m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_port_ctrl #(.DATA_W(W), .PORT_B(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_in_i(dir_in), .pin_data_i(pin_data),
    .stb_ack_ni(stb_n), .rd_ni(rd_n), .wr_ni(wr_n), .cpu_wdata_i(wdata),
    .bsr_we_i(bsr_we), .bsr_bit_i(bsr_bit), .bsr_val_i(bsr_val),
    .rd_data_o(rdat[0]), .port_data_o(pdat[0]), .buf_flag_o(bflag[0]),
    .intr_o(intr[0]), .status_o(stat[0])
  );

  hs_port_ctrl #(.DATA_W(W), .PORT_B(1'b1)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .dir_in_i(dir_in), .pin_data_i(pin_data),
    .stb_ack_ni(stb_n), .rd_ni(rd_n), .wr_ni(wr_n), .cpu_wdata_i(wdata),
    .bsr_we_i(bsr_we), .bsr_bit_i(bsr_bit), .bsr_val_i(bsr_val),
    .rd_data_o(rdat[1]), .port_data_o(pdat[1]), .buf_flag_o(bflag[1]),
    .intr_o(intr[1]), .status_o(stat[1])
  );

  function automatic logic [2:0] inte_pos(int p, logic din);
    if (p == 1) return 3'd2;
    return din ? 3'd4 : 3'd6;
  endfunction

  function automatic logic exp_intr(int p);
    return dir_in ? (m_inte[p] & m_ibf[p]) : (m_inte[p] & m_obfn[p]);
  endfunction

  function automatic logic [7:0] exp_stat(int p);
    logic [7:0] s = '0;
    logic bf = dir_in ? m_ibf[p] : m_obfn[p];
    if (p == 1) begin
      s[0] = exp_intr(p); s[1] = bf; s[2] = m_inte[p];
    end else if (dir_in) begin
      s[3] = exp_intr(p); s[4] = m_inte[p]; s[5] = bf;
    end else begin
      s[3] = exp_intr(p); s[6] = m_inte[p]; s[7] = bf;
    end
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    for (int p = 0; p < 2; p++) begin
      chk({tag, " R2 rd_data"}, 32'(rdat[p]), 32'(m_in));
      chk({tag, " R5 port_data"}, 32'(pdat[p]), 32'(m_out));
      chk({tag, " R5 buf_flag"}, 32'(bflag[p]), 32'(dir_in ? m_ibf[p] : m_obfn[p]));
      chk({tag, " R4/R6 intr"}, 32'(intr[p]), 32'(exp_intr(p)));
      chk({tag, " R8 status"}, 32'(stat[p]), 32'(exp_stat(p)));
    end
  endtask

  task automatic pulse_line(logic [W-1:0] d);
    pin_data = d; stb_n = 1'b0;
    cyc(5);
    stb_n = 1'b1;
    cyc(5);
    pin_data = ~d;
    for (int p = 0; p < 2; p++)
      if (dir_in) m_ibf[p] = 1'b1; else m_obfn[p] = 1'b1;
    if (dir_in) m_in = d;
  endtask

  task automatic cpu_read();
    rd_n = 1'b0;
    cyc(2);
    if (dir_in) for (int p = 0; p < 2; p++) begin
      chk("R3 intr low during read", 32'(intr[p]), 32'd0);
      chk("R3 flag held during read", 32'(bflag[p]), 32'(m_ibf[p]));
    end
    rd_n = 1'b1;
    cyc(3);
    if (dir_in) for (int p = 0; p < 2; p++) m_ibf[p] = 1'b0;
  endtask

  task automatic cpu_write(logic [W-1:0] d);
    wdata = d; wr_n = 1'b0;
    cyc(2);
    if (!dir_in) for (int p = 0; p < 2; p++)
      chk("R6 intr low during write", 32'(intr[p]), 32'd0);
    wr_n = 1'b1;
    cyc(3);
    wdata = ~d;
    if (!dir_in) begin
      m_out = d;
      for (int p = 0; p < 2; p++) m_obfn[p] = 1'b0;
    end
  endtask

  task automatic bsr(logic [2:0] b, logic v);
    bsr_we = 1'b1; bsr_bit = b; bsr_val = v;
    cyc(1);
    bsr_we = 1'b0;
    cyc(2);
    for (int p = 0; p < 2; p++) if (b == inte_pos(p, dir_in)) m_inte[p] = v;
  endtask

  task automatic set_dir(logic d);
    if (d != dir_in) begin
      dir_in = d;
      for (int p = 0; p < 2; p++) begin
        m_ibf[p] = 1'b0; m_obfn[p] = 1'b1; m_inte[p] = 1'b0;
      end
    end
    cyc(3);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      m_ibf[p] = 1'b0; m_obfn[p] = 1'b1; m_inte[p] = 1'b0;
    end
    m_in = '0; m_out = '0;
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    check_all("reset R1");

    // directed: input capture, interrupt, read
    bsr(3'd4, 1'b1); bsr(3'd2, 1'b1);
    check_all("inte set R7");
    pulse_line(8'hA5);
    check_all("strobe R2 R4");
    cpu_read();
    check_all("read R3");
    // non-matching set/reset has no effect
    pulse_line(8'h3C);
    bsr(3'd5, 1'b0); bsr(3'd0, 1'b0);
    check_all("other bit R7");
    bsr(3'd4, 1'b0);
    check_all("clear A inte R7");
    cpu_write(8'h77);
    check_all("write ignored in input R5");
    // output direction
    set_dir(1'b0);
    check_all("dir change R9");
    bsr(3'd6, 1'b1); bsr(3'd2, 1'b1);
    check_all("out inte R6");
    cpu_write(8'h5A);
    check_all("write R5");
    pulse_line(8'hFF);
    check_all("ack R5 R6");
    set_dir(1'b1);
    check_all("dir back R9");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 10;
      case (op)
        0, 1: pulse_line(8'($urandom));
        2, 3: cpu_read();
        4, 5: cpu_write(8'($urandom));
        6, 7: bsr(3'($urandom), 1'($urandom));
        8: bsr(inte_pos($urandom % 2, dir_in), 1'b1);
        default: if ($urandom % 4 == 0) set_dir(~dir_in); else cyc(2);
      endcase
      check_all("random");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule